// File: doc/BRIEF.md
# Restoring Binary Long Divider

This block divides one unsigned W-bit integer by another over several clock cycles. It finds one quotient bit per cycle. It starts at the top bit of the dividend and works down, because each quotient bit depends on the partial remainder that the previous bit leaves behind. Each step forms a trial difference with a single subtractor. The borrow out of that subtraction decides whether the divisor fits, and the same difference becomes the new partial remainder when it does. The new quotient bit is shifted in at the bottom.

To use the block, a client presents both operands with `start` while `busy` is low. The block pulses `done` when the result is ready. The quotient then sits in `lo` and the remainder in `hi`, and both stay there until the next operation completes. A zero divisor is an invalid input. The block rejects it straight away: it raises `div_by_zero` and does not run the long division.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `busy`, `done`, `div_by_zero`, `lo` and `hi` are all zero.
- R2: For a nonzero divisor, `lo` holds the quotient and `hi` the remainder at completion, so that dividend = `lo` × divisor + `hi` and `hi` < divisor. This includes a divisor larger than the dividend (`lo` = 0, `hi` = dividend) and all-ones operands.
- R3: For a nonzero divisor, `done` is seen exactly W clock edges after the edge that accepts `start`, one quotient bit per edge.
- R4: `done` is high for a single cycle per accepted operation and is never high when no operation is pending.
- R5: For a zero divisor, `done` and `div_by_zero` are seen on the edge after acceptance, with `lo` all ones and `hi` equal to the dividend.
- R6: While `busy` is high, `start` and any change of operands are ignored. The running result is unaffected and no extra `done` appears.
- R7: `busy` is high from the accepting edge until the edge that raises `done`, and low otherwise.
- R8: `lo`, `hi` and `div_by_zero` hold their values between completions. A normal completion clears `div_by_zero`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; accepted only when `busy` is low |
| dividend | input | W | Unsigned dividend, sampled on acceptance |
| divisor | input | W | Unsigned divisor, sampled on acceptance |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_by_zero | output | 1 | Last completed operation had a zero divisor |
| lo | output | W | Quotient |
| hi | output | W | Remainder |

## Verification
At W=4 the bench covers every operand pair, including every zero-divisor case. At W=32 it adds corner operands and random pairs. The corner operands are all-ones values, a divisor of one, and a divisor above the dividend. A design that misread the borrow, or that shifted in the wrong operand bit, would break the identity dividend = quotient × divisor + remainder, or would leave a remainder that is not below the divisor. The bench times each `done` against the accepting edge. An off-by-one step counter would therefore show up as a late or early pulse, or as a result that is missing or extra. Operands are also changed and `start` is re-asserted in the middle of a division, and a zero divisor is followed by a normal division. These runs expose a design that restarts while busy, or that keeps a stale error flag.

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_by_zero,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  part_q, quo_q, dvs_q;
  logic [CW-1:0] step_q;
  logic [W:0]    shifted, trial;
  logic          borrow, fits, last;
  logic [W-1:0]  part_nx, quo_nx;
  logic          accept;

  assign accept  = start && !busy;
  assign shifted = {part_q, quo_q[W-1]};
  assign {borrow, trial} = {1'b0, shifted} - {2'b00, dvs_q};
  assign fits    = !borrow;
  assign part_nx = fits ? trial[W-1:0] : shifted[W-1:0];
  assign quo_nx  = {quo_q[W-2:0], 1'b0} | {{(W-1){1'b0}}, fits};
  assign last    = step_q == CW'(W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      div_by_zero <= 1'b0;
      lo          <= '0;
      hi          <= '0;
      part_q      <= '0;
      quo_q       <= '0;
      dvs_q       <= '0;
      step_q      <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (divisor == '0) begin
          done        <= 1'b1;
          div_by_zero <= 1'b1;
          lo          <= '1;
          hi          <= dividend;
        end else begin
          busy   <= 1'b1;
          part_q <= '0;
          quo_q  <= dividend;
          dvs_q  <= divisor;
          step_q <= '0;
        end
      end else if (busy) begin
        part_q <= part_nx;
        quo_q  <= quo_nx;
        step_q <= step_q + 1'b1;
        if (last) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          div_by_zero <= 1'b0;
          lo          <= quo_nx;
          hi          <= part_nx;
        end
      end
    end
  end

  AST_PART_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> part_q < dvs_q); // R2
  AST_TRIAL_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fits) |-> !trial[W]); // R2
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> hi < dvs_q); // R2
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step_q < CW'(W)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !done); // R4
  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && divisor == '0) |=> (done && div_by_zero && lo == '1 && hi == $past(dividend))); // R5
  AST_NONZERO_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && divisor != '0) |=> (busy && !done)); // R3
  AST_BUSY_KEEPS_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(dvs_q))); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(lo) && $stable(hi) && $stable(div_by_zero))); // R8
endmodule

// File: tb/restoring_divider_tb_top.sv
`timescale 1ns/1ps
module restoring_divider_tb_top;
  localparam int WB = 32;
  localparam int WS = 4;

  typedef struct {
    logic [31:0] a, d, q, r;
    logic        dz;
    int          cyc;
    int          lat;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0;
  int nfail = 0;
  bit summarized = 1'b0;

  exp_t qb[$];
  exp_t qs[$];

  logic          start_b = 1'b0, start_s = 1'b0;
  logic [WB-1:0] a_b = '0, d_b = '0;
  logic [WS-1:0] a_s = '0, d_s = '0;
  logic          busy_b, done_b, dz_b, busy_s, done_s, dz_s;
  logic [WB-1:0] lo_b, hi_b;
  logic [WS-1:0] lo_s, hi_s;

  restoring_divider #(.W(WB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start_b), .dividend(a_b), .divisor(d_b),
    .busy(busy_b), .done(done_b), .div_by_zero(dz_b), .lo(lo_b), .hi(hi_b));

  restoring_divider #(.W(WS)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .start(start_s), .dividend(a_s), .divisor(d_s),
    .busy(busy_s), .done(done_s), .div_by_zero(dz_s), .lo(lo_s), .hi(hi_s));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  task automatic summary();
    if (!summarized) begin
      summarized = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] d,
                                 input logic [31:0] ones, input int w);
    exp_t e;
    e.a = a; e.d = d; e.dz = (d == 0);
    e.q = (d == 0) ? ones : a / d;
    e.r = (d == 0) ? a : a % d;
    e.cyc = 0;
    e.lat = (d == 0) ? 0 : w;
    return e;
  endfunction

  task automatic run_big(input logic [WB-1:0] a, input logic [WB-1:0] d,
                         input bit disturb, input bit hold);
    exp_t e;
    e = model(a, d, '1, WB);
    @(negedge clk);
    start_b = 1'b1; a_b = a; d_b = d;
    @(posedge clk); #1;
    e.cyc = cyc;
    qb.push_back(e);
    @(negedge clk);
    start_b = 1'b0;
    if (d != 0) begin
      check("R7 busy after accept", {63'd0, busy_b}, 64'd1);
      if (disturb) begin
        start_b = 1'b1; a_b = ~a; d_b = d ^ 32'h5A5A_0001;
        repeat (3) @(negedge clk);
        start_b = 1'b0;
        check("R6 still busy under new start", {63'd0, busy_b}, 64'd1);
      end
    end
    while (!done_b) @(negedge clk);
    if (hold) begin
      repeat (3) @(negedge clk);
      check("R8 lo held", {32'd0, lo_b}, {32'd0, e.q});
      check("R8 hi held", {32'd0, hi_b}, {32'd0, e.r});
      check("R8 flag held", {63'd0, dz_b}, {63'd0, e.dz});
      check("R7 idle busy low", {63'd0, busy_b}, 64'd0);
    end
  endtask

  task automatic run_small(input logic [WS-1:0] a, input logic [WS-1:0] d);
    exp_t e;
    e = model({28'd0, a}, {28'd0, d}, 32'hF, WS);
    @(negedge clk);
    start_s = 1'b1; a_s = a; d_s = d;
    @(posedge clk); #1;
    e.cyc = cyc;
    qs.push_back(e);
    @(negedge clk);
    start_s = 1'b0;
    while (!done_s) @(negedge clk);
  endtask

  bit prev_b = 1'b0, prev_s = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_b) begin
        if (prev_b) check("R4 big done one cycle", 64'd1, 64'd0);
        if (qb.size() == 0) check("R4 big unexpected done", 64'd1, 64'd0);
        else begin
          exp_t e;
          e = qb.pop_front();
          check("R3 big latency", 64'(cyc), 64'(e.cyc + e.lat));
          check(e.dz ? "R5 big lo" : "R2 big quotient", {32'd0, lo_b}, {32'd0, e.q});
          check(e.dz ? "R5 big hi" : "R2 big remainder", {32'd0, hi_b}, {32'd0, e.r});
          check(e.dz ? "R5 big flag" : "R8 big flag cleared", {63'd0, dz_b}, {63'd0, e.dz});
          if (!e.dz) begin
            check("R2 big identity", 64'(lo_b) * 64'(e.d) + 64'(hi_b), 64'(e.a));
            check("R2 big rem<div", {63'd0, hi_b < e.d}, 64'd1);
          end
        end
      end
      if (done_s) begin
        if (prev_s) check("R4 small done one cycle", 64'd1, 64'd0);
        if (qs.size() == 0) check("R4 small unexpected done", 64'd1, 64'd0);
        else begin
          exp_t e;
          e = qs.pop_front();
          check("R3 small latency", 64'(cyc), 64'(e.cyc + e.lat));
          check(e.dz ? "R5 small lo" : "R2 small quotient", {60'd0, lo_s}, {32'd0, e.q});
          check(e.dz ? "R5 small hi" : "R2 small remainder", {60'd0, hi_s}, {32'd0, e.r});
          check(e.dz ? "R5 small flag" : "R8 small flag", {63'd0, dz_s}, {63'd0, e.dz});
          if (!e.dz)
            check("R2 small identity", 64'(lo_s) * 64'(e.d) + 64'(hi_s), 64'(e.a));
        end
      end
    end
    prev_b = done_b;
    prev_s = done_s;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", {63'd0, busy_b}, 64'd0);
    check("R1 done", {63'd0, done_b}, 64'd0);
    check("R1 flag", {63'd0, dz_b}, 64'd0);
    check("R1 lo", {32'd0, lo_b}, 64'd0);
    check("R1 hi", {32'd0, hi_b}, 64'd0);
    check("R1 small outputs", {54'd0, busy_s, done_s, dz_s, 1'b0, lo_s, hi_s}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 idle no done", {62'd0, done_b, done_s}, 64'd0);

    for (int a = 0; a < 16; a++)
      for (int d = 0; d < 16; d++)
        run_small(WS'(a), WS'(d));

    run_big(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1);
    run_big(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    run_big(32'd0, 32'd5, 1'b0, 1'b0);
    run_big(32'd1234, 32'h8000_0000, 1'b0, 1'b1);
    run_big(32'hDEAD_BEEF, 32'd0, 1'b0, 1'b1);
    run_big(32'd4209, 32'd77, 1'b0, 1'b1);
    run_big(32'h8000_0000, 32'd3, 1'b1, 1'b1);
    run_big(32'd7, 32'd0, 1'b0, 1'b0);
    run_big(32'd7, 32'd0, 1'b0, 1'b0);
    run_big(32'd1, 32'd1, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rd;
      ra = $urandom;
      rd = $urandom >> ($urandom % 32);
      run_big(ra, rd, (i % 7) == 0, (i % 11) == 0);
    end

    repeat (40) @(negedge clk);
    check("R4 no pending big results", 64'(qb.size()), 64'd0);
    check("R4 no pending small results", 64'(qs.size()), 64'd0);
    summary();
    $finish;
  end
endmodule